// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects eleven interrupt requests for a small 8-bit processor core and turns them into one request toward the core. The request carries a fixed vector address and a priority level. Each source has its own enable and a 2-bit priority, so there are four levels. A global enable masks every source at once and leaves all pending flags untouched. Sources 0 and 1 come from two active-low external pins. Each pin passes through a two-flop synchronizer and can be set to falling-edge or low-level triggering. Sources 2 to 10 are single-cycle request pulses from peripherals. Each pulse sets a pending flag, and that flag holds until the source is serviced.

The block keeps a one-bit-per-level in-service register, so nested service is tracked in hardware. A source can reach the core only if its priority is strictly above the highest level now in service. A small state machine presents the chosen source to the core.

- It has two states: `ST_IDLE` and `ST_PRESENT`.
- **IDLE→PRESENT (select):** taken when any source is eligible. The winner's index and level are latched on this transition.
- **PRESENT→IDLE (commit):** taken when the core asserts `irq_ack`. Commit marks the level in service and clears the latched pending flag.
- **PRESENT→IDLE (withdraw):** taken when the latched source stops being pending and enabled, or when the global enable drops. It changes no other state.

A return strobe from the core ends service of the highest active level.

Top module: `irqc_top`

## Requirements
- R1: Sources 2..10 map to `periph_req` bits 0..8. A high bit sets that source's pending flag. The flag stays set until the source is committed, and a set arriving in the same cycle as the clear takes precedence.
- R2: A source whose `src_en` bit is 0 is never presented, and neither is any source while `global_en` is 0. In both cases the pending flags are kept, so the request appears once it is enabled again.
- R3: `irq_req` is high only in `ST_PRESENT`. While it is high, `irq_src` gives the source and `irq_vec` equals 3 + 8 × source index. `irq_ack` during `irq_req` commits, and `irq_req` is low on the next cycle. `irq_ack` at any other time has no effect.
- R4: A source is eligible only if it is pending, enabled, and its priority (bits `[2i+1:2i]` of `src_prio`) is strictly above the highest set bit of `in_service`. When `in_service` is zero, any priority qualifies.
- R5: Among eligible sources, the highest priority wins. On a tie, the lowest source index wins.
- R6: On commit, bit L of `in_service` is set, where L is the presented level. `irq_reti` clears the highest set bit and has no effect when `in_service` is zero. If both happen in one cycle, the clear is applied before the set.
- R7: When `pin_edge[p]` = 1, a falling edge on `pin_n[p]` sets a latched flag for source p. The flag stays set after the pin rises and is cleared by commit. When `pin_edge[p]` = 0, source p is pending while the synchronized pin is low and is not cleared by commit.
- R8: A pin falling between edges shows up on `irq_req` after the 3rd rising edge in level mode and after the 4th in edge mode.
- R9: If the presented source is no longer pending, enabled, or globally enabled, `irq_req` drops on the next cycle and `in_service` is unchanged.
- R10: After reset, `irq_req` = 0, `in_service` = 0, all pending flags are clear, and the synchronizers hold 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 2 | Active-low external request pins (sources 0,1) |
| pin_edge | input | 2 | Per-pin trigger type: 1 falling edge, 0 low level |
| periph_req | input | 9 | Peripheral set pulses for sources 2..10 |
| src_en | input | 11 | Per-source enable |
| global_en | input | 1 | Global enable |
| src_prio | input | 22 | 2-bit priority per source, source i at [2i+1:2i] |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_reti | input | 1 | Core returns from a service routine |
| irq_req | output | 1 | Request presented to the core |
| irq_src | output | 4 | Presented source index |
| irq_vec | output | 16 | Presented vector address |
| irq_level | output | 2 | Presented priority level |
| in_service | output | 4 | Active service levels, one bit per level |

## Verification
The bench goes after these corner cases, and each one shows a specific wrong behaviour:

- **Equal-level request during service.** A design that compares with greater-or-equal would let this request through and present it.
- **Two requests of the same level.** A design with the wrong tie order would pick the higher index.
- **Return from a nested service.** A design that clears the wrong in-service bit would release a blocked source too early.
- **Edge-mode pin that rises before service.** A design that did not latch the edge would lose this request.
- **Level-mode pin that stays low.** It must be requested again after each return.
- **Level-mode pin released while presented.** A design without withdraw would leave `irq_req` stuck high.
- **Global mask.** A design that cleared flags when masked would never raise the queued requests.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_PRESENT
    } irqc_state_e;
endpackage

// File: rtl/irqc_pin_cond.sv
module irqc_pin_cond #(
    parameter int NUM_PIN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PIN-1:0] pin_n,
    input  logic [NUM_PIN-1:0] edge_mode,
    input  logic [NUM_PIN-1:0] clr,
    output logic [NUM_PIN-1:0] pend
);
    for (genvar g = 0; g < NUM_PIN; g++) begin : g_pin
        logic sy1, sy2, sy3, eflag, fall;

        assign fall = sy3 & ~sy2;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sy1   <= 1'b1;
                sy2   <= 1'b1;
                sy3   <= 1'b1;
                eflag <= 1'b0;
            end else begin
                sy1 <= pin_n[g];
                sy2 <= sy1;
                sy3 <= sy2;
                if (edge_mode[g] && fall)
                    eflag <= 1'b1;
                else if (clr[g])
                    eflag <= 1'b0;
            end
        end

        assign pend[g] = edge_mode[g] ? eflag : ~sy2;

        // R7
        edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_mode[g] && sy3 && !sy2) |=> eflag);
    end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM_SRC = 11,
    parameter int LVL_W   = 2,
    parameter int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]       cand,
    input  logic [NUM_SRC*LVL_W-1:0] prio,
    output logic                     valid,
    output logic [SRC_W-1:0]         idx,
    output logic [LVL_W-1:0]         level
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        level = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i] && (!valid || prio[i*LVL_W +: LVL_W] >= level)) begin
                valid = 1'b1;
                idx   = SRC_W'(i);
                level = prio[i*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC    = 11,
    parameter int NUM_PIN    = 2,
    parameter int NUM_LVL    = 4,
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8,
    parameter int SRC_W      = $clog2(NUM_SRC),
    parameter int LVL_W      = $clog2(NUM_LVL)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PIN-1:0]         pin_n,
    input  logic [NUM_PIN-1:0]         pin_edge,
    input  logic [NUM_SRC-NUM_PIN-1:0] periph_req,
    input  logic [NUM_SRC-1:0]         src_en,
    input  logic                       global_en,
    input  logic [NUM_SRC*LVL_W-1:0]   src_prio,
    input  logic                       irq_ack,
    input  logic                       irq_reti,
    output logic                       irq_req,
    output logic [SRC_W-1:0]           irq_src,
    output logic [VEC_W-1:0]           irq_vec,
    output logic [LVL_W-1:0]           irq_level,
    output logic [NUM_LVL-1:0]         in_service
);
    localparam int NUM_PER = NUM_SRC - NUM_PIN;

    irqc_state_e          state_q, state_d;
    logic [SRC_W-1:0]     lat_src_q;
    logic [LVL_W-1:0]     lat_lvl_q;
    logic [NUM_LVL-1:0]   isr_q, isr_d;
    logic [NUM_PER-1:0]   per_q, per_keep;
    logic [NUM_PIN-1:0]   pin_pend;
    logic [NUM_SRC-1:0]   pend, cand, clr_src;
    logic                 act_any, win_valid, commit, lat_live;
    logic [LVL_W-1:0]     act_lvl, win_lvl;
    logic [SRC_W-1:0]     win_idx;

    assign commit  = (state_q == ST_PRESENT) && irq_ack;
    assign clr_src = commit ? (NUM_SRC'(1) << lat_src_q) : '0;

    irqc_pin_cond #(.NUM_PIN(NUM_PIN)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (pin_n),
        .edge_mode (pin_edge),
        .clr       (clr_src[NUM_PIN-1:0]),
        .pend      (pin_pend)
    );

    // peripheral pending flags: set wins over clear
    assign per_keep = per_q & ~clr_src[NUM_SRC-1:NUM_PIN];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) per_q <= '0;
        else        per_q <= per_keep | periph_req;
    end

    assign pend = {per_q, pin_pend};

    // highest active service level
    always_comb begin
        act_any = 1'b0;
        act_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (isr_q[l]) begin
                act_any = 1'b1;
                act_lvl = LVL_W'(l);
            end
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cand
        assign cand[s] = pend[s] & src_en[s] & global_en &
                         (!act_any || (src_prio[s*LVL_W +: LVL_W] > act_lvl));
    end

    irqc_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .SRC_W(SRC_W)) u_arb (
        .cand  (cand),
        .prio  (src_prio),
        .valid (win_valid),
        .idx   (win_idx),
        .level (win_lvl)
    );

    assign lat_live = pend[lat_src_q] & src_en[lat_src_q] & global_en;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (win_valid) state_d = ST_PRESENT;
            ST_PRESENT: if (irq_ack || !lat_live) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // winner latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_src_q <= '0;
            lat_lvl_q <= '0;
        end else if (state_q == ST_IDLE && win_valid) begin
            lat_src_q <= win_idx;
            lat_lvl_q <= win_lvl;
        end
    end

    // in-service stack: return clears first, then commit sets
    always_comb begin
        isr_d = isr_q;
        if (irq_reti && act_any) isr_d[act_lvl] = 1'b0;
        if (commit)              isr_d[lat_lvl_q] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_d;
    end

    // outputs
    always_comb begin
        irq_req    = (state_q == ST_PRESENT);
        irq_src    = lat_src_q;
        irq_level  = lat_lvl_q;
        irq_vec    = VEC_W'(VEC_BASE) + VEC_W'(lat_src_q) * VEC_W'(VEC_STRIDE);
        in_service = isr_q;
    end

    // R4
    preempt_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (!act_any || (irq_level > act_lvl)));
    // R3
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);
    // R6
    isr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(irq_req && irq_ack) && !irq_reti) |=> $stable(in_service));
    // R2
    global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && !global_en) |=> !irq_req);
    // R1
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((per_q & $past(per_keep)) == $past(per_keep)));
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    localparam int NS = 11;
    localparam int NP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pin_n = 2'b11;
    logic [1:0]  pin_edge = 2'b01;
    logic [8:0]  periph_req = '0;
    logic [10:0] src_en = '1;
    logic        global_en = 1'b1;
    logic [21:0] src_prio = '0;
    logic        irq_ack = 1'b0;
    logic        irq_reti = 1'b0;
    logic        irq_req;
    logic [3:0]  irq_src;
    logic [15:0] irq_vec;
    logic [1:0]  irq_level;
    logic [3:0]  in_service;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .pin_edge(pin_edge),
        .periph_req(periph_req), .src_en(src_en), .global_en(global_en),
        .src_prio(src_prio), .irq_ack(irq_ack), .irq_reti(irq_reti),
        .irq_req(irq_req), .irq_src(irq_src), .irq_vec(irq_vec),
        .irq_level(irq_level), .in_service(in_service)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_s1[NP], m_s2[NP], m_s3[NP], m_ef[NP];
    bit m_pf[NS];
    bit m_isr[4];
    bit m_pres;
    int m_src, m_lvl;

    function automatic int prio_of(int i);
        return int'(src_prio[2*i +: 2]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_s1[p] = 1; m_s2[p] = 1; m_s3[p] = 1; m_ef[p] = 0;
            end
            for (int i = 0; i < NS; i++) m_pf[i] = 0;
            for (int l = 0; l < 4; l++) m_isr[l] = 0;
            m_pres = 0; m_src = 0; m_lvl = 0;
        end else begin
            bit pend[NS];
            int top, best;
            bit commit, live;
            for (int i = 0; i < NS; i++)
                pend[i] = (i < NP) ? (pin_edge[i] ? m_ef[i] : !m_s2[i]) : m_pf[i];
            top = -1;
            for (int l = 0; l < 4; l++) if (m_isr[l]) top = l;
            best = -1;
            for (int i = 0; i < NS; i++)
                if (pend[i] && src_en[i] && global_en && prio_of(i) > top)
                    if (best < 0 || prio_of(i) > prio_of(best)) best = i;
            commit = m_pres && irq_ack;
            live = pend[m_src] && src_en[m_src] && global_en;
            if (irq_reti && top >= 0) m_isr[top] = 0;
            if (commit) m_isr[m_lvl] = 1;
            for (int p = 0; p < NP; p++) begin
                if (pin_edge[p] && m_s3[p] && !m_s2[p]) m_ef[p] = 1;
                else if (commit && m_src == p) m_ef[p] = 0;
            end
            for (int i = NP; i < NS; i++) begin
                if (periph_req[i-NP]) m_pf[i] = 1;
                else if (commit && m_src == i) m_pf[i] = 0;
            end
            if (m_pres) begin
                if (commit || !live) m_pres = 0;
            end else if (best >= 0) begin
                m_pres = 1; m_src = best; m_lvl = prio_of(best);
            end
            for (int p = 0; p < NP; p++) begin
                m_s3[p] = m_s2[p]; m_s2[p] = m_s1[p]; m_s1[p] = pin_n[p];
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int misr;
            misr = 0;
            for (int l = 0; l < 4; l++) if (m_isr[l]) misr += (1 << l);
            chk(irq_req == m_pres, "R3 model irq_req", irq_req, m_pres);
            if (m_pres) begin
                chk(irq_src == 4'(m_src), "R5 model irq_src", irq_src, m_src);
                chk(irq_vec == 16'(3 + 8*m_src), "R3 model irq_vec", irq_vec, 3 + 8*m_src);
                chk(irq_level == 2'(m_lvl), "R4 model irq_level", irq_level, m_lvl);
            end
            chk(in_service == 4'(misr), "R6 model in_service", in_service, misr);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic setp(input int i, input int l);
        src_prio[2*i +: 2] = 2'(l);
    endtask

    task automatic pulse_src(input int i);
        periph_req[i-NP] = 1'b1;
        @(negedge clk);
        periph_req[i-NP] = 1'b0;
    endtask

    task automatic wait_req(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq_req && n < 40);
    endtask

    task automatic do_ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic do_reti();
        irq_reti = 1'b1;
        @(negedge clk);
        irq_reti = 1'b0;
    endtask

    task automatic expect_quiet(input int cycles, input string tag);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            chk(!irq_req, tag, irq_req, 0);
        end
    endtask

    task automatic expect_src(input int s, input string tag);
        int n;
        wait_req(n);
        chk(irq_req && irq_src == 4'(s), tag, irq_src, s);
    endtask

    initial begin
        int n;
        @(negedge clk);
        @(negedge clk);
        // R10 reset state
        chk(irq_req == 0, "R10 reset irq_req", irq_req, 0);
        chk(in_service == 0, "R10 reset in_service", in_service, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 basic presentation, vector
        setp(3, 1);
        pulse_src(3);
        expect_src(3, "R3 src3 presented");
        chk(irq_vec == 16'd27, "R3 vector src3", irq_vec, 27);
        chk(irq_level == 2'd1, "R3 level src3", irq_level, 1);
        do_ack();
        chk(!irq_req, "R3 req drops after ack", irq_req, 0);
        chk(in_service == 4'b0010, "R6 isr after ack", in_service, 2);

        // R4 equal level blocked, higher preempts
        setp(4, 1); setp(5, 2);
        pulse_src(4);
        expect_quiet(6, "R4 equal level blocked");
        pulse_src(5);
        expect_src(5, "R4 higher level preempts");
        do_ack();
        chk(in_service == 4'b0110, "R6 nested isr", in_service, 6);
        do_reti();
        chk(in_service == 4'b0010, "R6 reti clears top bit", in_service, 2);
        expect_quiet(5, "R4 src4 still blocked at level1");
        do_reti();
        chk(in_service == 4'b0000, "R6 second reti", in_service, 0);
        expect_src(4, "R1 src4 flag held until service");
        do_ack();
        do_reti();

        // R2 global mask, R5 tie break
        global_en = 1'b0;
        setp(6, 3); setp(7, 3); setp(2, 0);
        periph_req[6-NP] = 1'b1; periph_req[7-NP] = 1'b1; periph_req[2-NP] = 1'b1;
        @(negedge clk);
        periph_req = '0;
        expect_quiet(5, "R2 global mask");
        global_en = 1'b1;
        expect_src(6, "R5 tie lowest index");
        do_ack();
        do_reti();
        expect_src(7, "R5 second of tie");
        do_ack();
        do_reti();
        expect_src(2, "R2 lower level kept pending");
        do_ack();
        do_reti();

        // R2 per-source enable
        src_en[8] = 1'b0;
        setp(8, 1);
        pulse_src(8);
        expect_quiet(5, "R2 disabled source");
        src_en[8] = 1'b1;
        expect_src(8, "R2 enabled later");
        do_ack();
        do_reti();

        // R7 / R8 edge-mode pin 0
        setp(0, 2);
        pin_n[0] = 1'b0;
        wait_req(n);
        chk(n == 4, "R8 edge latency", n, 4);
        pin_n[0] = 1'b1;
        chk(irq_src == 4'd0 && irq_vec == 16'd3, "R7 edge pin vector", irq_vec, 3);
        do_ack();
        chk(in_service == 4'b0100, "R6 isr level2", in_service, 4);
        do_reti();
        expect_quiet(6, "R7 edge flag cleared on service");

        // R7 / R8 level-mode pin 1
        setp(1, 1);
        pin_n[1] = 1'b0;
        wait_req(n);
        chk(n == 3, "R8 level latency", n, 3);
        chk(irq_src == 4'd1, "R7 level pin src", irq_src, 1);
        do_ack();
        do_reti();
        expect_src(1, "R7 level pin requests again");
        // R9 withdraw
        pin_n[1] = 1'b1;
        repeat (4) @(negedge clk);
        chk(!irq_req, "R9 withdrawn request", irq_req, 0);
        chk(in_service == 0, "R9 no service change", in_service, 0);

        // R3 ack while idle ignored
        do_ack();
        chk(!irq_req && in_service == 0, "R3 idle ack ignored", in_service, 0);
        expect_quiet(3, "R3 idle ack no request");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule